// File: doc/BRIEF.md
# Device Command/Status Handshake Register

This block is the register set that sits between a CPU bus and one peripheral. It holds four 32-bit words, so each device takes 16 bytes of address space. The word index is `bus_idx`: 0 is STATUS, 1 is COMMAND, 2 is DATA0 and 3 is DATA1. The CPU first writes the operation's parameters into the two data words and then writes an operation code into COMMAND. The block shows a busy code in STATUS and raises `op_req` toward the device. When the device reports completion with a result code, STATUS takes that code and the interrupt request `irq` goes high.

The CPU reads the outcome from STATUS and then clears the interrupt. It can do this with an explicit acknowledge command. It can also issue the next command directly, because any command write acknowledges a pending completion. While an operation is in flight, every word is frozen and all CPU writes are discarded. The device side is behavioural: a one-cycle `dev_done` strobe together with `dev_result` ends the operation.

Top module: `dev_handshake_reg`

## Requirements
- R1: After reset, STATUS reads 1, COMMAND, DATA0 and DATA1 read 0, and both `irq` and `op_req` are low.
- R2: When the block is not busy, a write to word index 1 (COMMAND) with a code of 2 or higher is stored in COMMAND and on `op_code`. From the next cycle STATUS reads 3 (busy), and `op_req` stays high until completion.
- R3: A `dev_done` strobe while busy sets STATUS to `dev_result` on the next cycle. A result below 5 is recorded as 5. In the same next cycle `irq` rises and `op_req` falls.
- R4: While STATUS is 3, bus writes to any word have no effect on any word.
- R5: A COMMAND write of code 1 (acknowledge) when not busy pulls `irq` low in the same cycle as the write, and STATUS reads 1 from the next cycle.
- R6: A COMMAND write of code 2 or higher while a completion interrupt is pending pulls `irq` low in the same cycle as the write and starts the new operation (STATUS 3 next cycle).
- R7: A COMMAND write of code 0 (reset) when not busy clears `irq` in the same cycle. From the next cycle STATUS reads 1 and COMMAND, DATA0 and DATA1 read 0.
- R8: STATUS (word index 0) is read-only: a bus write to it changes nothing.
- R9: When not busy, including while a completion is pending, writes to word index 2 (DATA0) and word index 3 (DATA1) are stored and read back from the next cycle, and `irq` is unaffected.
- R10: A `dev_done` strobe when not busy is ignored: STATUS and `irq` keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | CPU write strobe |
| bus_idx | input | 2 | Word index: 0 STATUS, 1 COMMAND, 2 DATA0, 3 DATA1 |
| bus_wdata | input | DATA_W | CPU write data |
| bus_rdata | output | DATA_W | Combinational read of the indexed word |
| dev_done | input | 1 | Device completion strobe |
| dev_result | input | RES_W | Device result code, taken with `dev_done` |
| op_req | output | 1 | High while an operation is in flight |
| op_code | output | DATA_W | Current COMMAND word |
| irq | output | 1 | Completion interrupt request |

## Verification
Two pairs of events can land in the same cycle. The first is a device completion arriving together with a CPU write. The bench drives `dev_done` and a DATA0 write in one cycle, and the reference model expects the completion to be taken and the write to be dropped. The second is a command write arriving while an interrupt is pending. The bench issues a new operation and an acknowledge directly on top of a pending completion, and it checks `irq` before the clock edge to confirm it is already low in the write cycle.

// File: rtl/dev_handshake_reg.sv
module dev_handshake_reg #(
  parameter int DATA_W = 32,
  parameter int RES_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [1:0]        bus_idx,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              dev_done,
  input  logic [RES_W-1:0]  dev_result,
  output logic              op_req,
  output logic [DATA_W-1:0] op_code,
  output logic              irq
);

  localparam logic [1:0] W_STAT = 2'd0;
  localparam logic [1:0] W_CMD  = 2'd1;
  localparam logic [1:0] W_D0   = 2'd2;
  localparam logic [1:0] W_D1   = 2'd3;

  localparam logic [DATA_W-1:0] ST_READY = DATA_W'(1);
  localparam logic [DATA_W-1:0] ST_BUSY  = DATA_W'(3);
  localparam logic [DATA_W-1:0] ST_DONE  = DATA_W'(5);
  localparam logic [DATA_W-1:0] C_RESET  = DATA_W'(0);
  localparam logic [DATA_W-1:0] C_ACK    = DATA_W'(1);

  logic [DATA_W-1:0] status_q, cmd_q, d0_q, d1_q;
  logic              pend_q;
  logic              busy, cmd_wr;
  logic [DATA_W-1:0] res_ext, done_code;

  assign busy      = (status_q == ST_BUSY);
  assign cmd_wr    = bus_we && !busy && (bus_idx == W_CMD);
  assign res_ext   = DATA_W'(dev_result);
  assign done_code = (res_ext < ST_DONE) ? ST_DONE : res_ext;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= ST_READY;
      cmd_q    <= '0;
      d0_q     <= '0;
      d1_q     <= '0;
      pend_q   <= 1'b0;
    end else if (busy) begin
      if (dev_done) begin
        status_q <= done_code;
        pend_q   <= 1'b1;
      end
    end else if (bus_we) begin
      case (bus_idx)
        W_CMD: begin
          cmd_q  <= bus_wdata;
          pend_q <= 1'b0;
          if (bus_wdata == C_RESET) begin
            status_q <= ST_READY;
            d0_q     <= '0;
            d1_q     <= '0;
          end else if (bus_wdata == C_ACK) begin
            status_q <= ST_READY;
          end else begin
            status_q <= ST_BUSY;
          end
        end
        W_D0:    d0_q <= bus_wdata;
        W_D1:    d1_q <= bus_wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (bus_idx)
      W_STAT:  bus_rdata = status_q;
      W_CMD:   bus_rdata = cmd_q;
      W_D0:    bus_rdata = d0_q;
      default: bus_rdata = d1_q;
    endcase
  end

  assign op_req  = busy;
  assign op_code = cmd_q;
  assign irq     = pend_q && !cmd_wr;

  AST_STATUS_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q == ST_READY) || (status_q == ST_BUSY) || (status_q >= ST_DONE)); // R3
  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && !op_req && bus_idx == W_CMD && bus_wdata > C_ACK) |=> (op_req && bus_rdata == bus_rdata && status_q == ST_BUSY)); // R2
  AST_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    op_req |=> ($stable(cmd_q) && $stable(d0_q) && $stable(d1_q))); // R4
  AST_DONE_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (op_req && dev_done) |=> (irq && !op_req && status_q >= ST_DONE)); // R3
  AST_IRQ_COMPLETE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (status_q >= ST_DONE)); // R3
  AST_ACK_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && !op_req && bus_idx == W_CMD && bus_wdata == C_ACK) |=> (status_q == ST_READY && !irq)); // R5
  AST_IDLE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_req && !bus_we && dev_done) |=> ($stable(status_q) && $stable(pend_q))); // R10

endmodule

// File: tb/test_dev_handshake_reg.sv
module test_dev_handshake_reg;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [1:0]  bus_idx = 2'd0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        dev_done = 1'b0;
  logic [7:0]  dev_result = '0;
  logic        op_req;
  logic [31:0] op_code;
  logic        irq;

  int errors = 0;
  int checks = 0;

  int unsigned m_word[4];
  bit          m_pend;

  always #4 clk = ~clk;

  dev_handshake_reg #(.DATA_W(32), .RES_W(8)) i_dev_handshake_reg (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_idx(bus_idx),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .dev_done(dev_done),
    .dev_result(dev_result), .op_req(op_req), .op_code(op_code), .irq(irq)
  );

  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic bit m_busy();
    return m_word[0] == 3;
  endfunction

  task automatic step(input bit we, input int idx, input int unsigned wd,
                      input bit dn, input int res, input string tag);
    bit exp_irq;
    @(negedge clk);
    bus_we = we; bus_idx = 2'(idx); bus_wdata = wd;
    dev_done = dn; dev_result = 8'(res);
    #1;
    exp_irq = m_pend && !(we && !m_busy() && idx == 1);
    chk(tag, "rdata", bus_rdata, m_word[idx]);
    chk(tag, "irq", irq, exp_irq);
    chk(tag, "op_req", op_req, m_busy());
    chk(tag, "op_code", op_code, m_word[1]);
    @(posedge clk);
    if (m_busy()) begin
      if (dn) begin
        m_word[0] = (res < 5) ? 5 : res;
        m_pend = 1'b1;
      end
    end else if (we) begin
      if (idx == 1) begin
        m_word[1] = wd;
        m_pend = 1'b0;
        if (wd == 0) begin
          m_word[0] = 1; m_word[2] = 0; m_word[3] = 0;
        end else if (wd == 1) m_word[0] = 1;
        else m_word[0] = 3;
      end else if (idx == 2) m_word[2] = wd;
      else if (idx == 3) m_word[3] = wd;
    end
  endtask

  task automatic peek_all(input string tag);
    for (int k = 0; k < 4; k++) step(1'b0, k, 0, 1'b0, 0, tag);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    m_word[0] = 1; m_word[1] = 0; m_word[2] = 0; m_word[3] = 0; m_pend = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    peek_all("R1 reset");

    step(1, 2, 32'hAAAA_0001, 0, 0, "R9 data0 write");
    step(1, 3, 32'h5555_0002, 0, 0, "R9 data1 write");
    peek_all("R9 readback");

    step(1, 0, 32'd77, 0, 0, "R8 status write");
    step(0, 0, 0, 0, 0, "R8 status unchanged");

    step(0, 0, 0, 1, 9, "R10 idle done");
    step(0, 0, 0, 0, 0, "R10 no effect");

    step(1, 1, 7, 0, 0, "R2 start op");
    step(1, 2, 32'hDEAD, 0, 0, "R4 data0 locked");
    step(1, 1, 1, 0, 0, "R4 command locked");
    step(1, 3, 32'hBEEF, 0, 0, "R4 data1 locked");
    step(1, 0, 32'd1, 0, 0, "R4 status locked");
    peek_all("R4 frozen");

    step(1, 2, 32'h1234, 1, 9, "R3 done with write");
    peek_all("R3 completed");

    step(1, 3, 32'h0F0F, 0, 0, "R9 write while pending");
    step(0, 3, 0, 0, 0, "R9 pending kept");

    step(1, 1, 1, 0, 0, "R5 acknowledge");
    peek_all("R5 ready");

    step(1, 1, 2, 0, 0, "R2 second op");
    step(0, 0, 0, 1, 2, "R3 low result");
    step(0, 0, 0, 0, 0, "R3 clamped");

    step(1, 1, 4, 0, 0, "R6 implicit ack");
    step(0, 0, 0, 0, 0, "R6 busy again");
    step(0, 0, 0, 1, 6, "R3 third done");
    step(0, 0, 0, 0, 0, "R3 status six");

    step(1, 1, 0, 0, 0, "R7 reset command");
    peek_all("R7 cleared");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule